// File: doc/BRIEF.md
# Burst-Read Register Port with Sample-Queue Pop

This block is the serial register front end of a sensor sample queue. A host drives a four-wire serial link (chip select, clock, data in, data out) in clock-polarity-high, capture-on-rising mode. The first byte of every chip-select frame is a command. It carries a direction bit, an auto-increment bit and a 6-bit start address. Every following byte either returns the addressed register, most significant bit first, or writes it. When the auto-increment bit is set, the register pointer steps to the next address after each byte.

Six read-only data addresses show the entry at the head of an external sample queue. The block asks the queue to drop that head entry exactly once per frame that read a data register. The request goes out either on the final clock of the last data byte or when chip select is released. As a result, two single-byte frames return bytes from different sample sets. A status address reports the queue fill level. After each pop, that value is frozen for a settling window and so reads back stale during it. A control address holds the queue mode, the trigger-pin select and the sample threshold for the rest of the queue logic.

All serial inputs are resynchronised into the system clock, which must run several times faster than the serial clock.

Top module: `burst_reg_port`

## Requirements
- R1: The command byte is decoded as follows. Bit 7 = 1 selects a read and 0 selects a write. Bit 6 = 1 enables auto-increment. Bits 5..0 give the start address. Every later byte of the frame is a data byte.
- R2: Data in is captured on rising serial-clock edges. Read bytes go out most significant bit first, and each bit changes after a falling edge. Data out is 0 during the command byte and while chip select is high.
- R3: Address 0x32+i (i = 0..5) returns byte i, bits [8i+7:8i], of the queue head entry. The six bytes are X low, X high, Y low, Y high, Z low and Z high.
- R4: With auto-increment set, the pointer advances by one after every data byte. Without it, every data byte of the frame uses the same address and repeats the same value.
- R5: A pop is requested on the last rising clock of a read byte at address 0x37, while chip select is still low.
- R6: If no pop has been requested yet, a pop is requested on chip-select release when at least one complete data-register byte was read in the frame. Frames that carry only a command, only non-data reads, or writes request no pop.
- R7: A frame requests at most one pop, and each request lasts one clock cycle.
- R8: Address 0x38 is a read/write control byte. Bits 7..6 are the mode, bit 5 is the trigger select and bits 4..0 are the sample threshold. The control byte resets to 0. Writes to any other address change nothing.
- R9: Address 0x39 reads the status byte. Bit 7 is the triggered flag, bit 6 is 0 and bits 5..0 are the queue entry count.
- R10: For POP_SETTLE clock cycles after a pop request, the status byte keeps the value it had before the pop.
- R11: Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| spiCsN | input | 1 | Chip select, active low |
| spiSclk | input | 1 | Serial clock, idles high |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| fifoHead | input | 48 | Head entry of the sample queue, byte i = register 0x32+i |
| fifoCount | input | 6 | Current queue entry count |
| fifoTriggered | input | 1 | Queue triggered flag |
| fifoPop | output | 1 | One-cycle request to drop the head entry |
| ctrlMode | output | 2 | Control byte bits 7..6 |
| ctrlTrigSel | output | 1 | Control byte bit 5 |
| ctrlSamples | output | 5 | Control byte bits 4..0 |

## Verification
Every serial input passes two synchroniser flops and an edge detector, so each result lands three system cycles after the serial event that causes it. Data out changes three cycles after a falling serial edge. A written byte or a pop appears three cycles after the final rising edge, or three cycles after chip select rises. The bench holds each serial clock phase for six system cycles. It samples data out at the end of the low phase, and it reads the pop count and control outputs only after a full phase or an idle gap has passed. The status-freeze check is timed so that the status byte is loaded well inside the settling window after a pop, and the fresh-value check is taken after the window has closed.

// File: rtl/burst_reg_pkg.sv
package burst_reg_pkg;
  localparam int ADDR_W = 6;

  typedef struct packed {
    logic              frameIdle;
    logic              fallEdge;
    logic              txActive;
    logic [2:0]        bitIdx;
    logic              loadTx;
    logic [ADDR_W-1:0] loadAddr;
    logic              writeCtrl;
    logic [7:0]        wrData;
    logic              popNow;
  } portStrobes_t;
endpackage

// File: rtl/burst_reg_ctl.sv
module burst_reg_ctl
  import burst_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                NUM_DATA    = 6,
  parameter logic [ADDR_W-1:0] DATA_BASE   = 6'h32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 6'h38
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         spiCsN,
  input  logic         spiSclk,
  input  logic         spiMosi,
  output portStrobes_t strb
);
  localparam logic [ADDR_W-1:0] LAST_DATA = DATA_BASE + ADDR_W'(NUM_DATA - 1);

  logic [SYNC_STAGES-1:0] csSync, sclkSync, mosiSync;
  logic csS, sclkS, mosiS, csPrev, sclkPrev;
  logic rise, fall, csRise, byteDone;
  logic inCmd, isRead, isMulti, touched, popped;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] ptr, nextPtr;

  // input resynchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '1;
      mosiSync <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS      = csSync[SYNC_STAGES-1];
  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign rise     = !csS && sclkS && !sclkPrev;
  assign fall     = !csS && !sclkS && sclkPrev;
  assign csRise   = csS && !csPrev;
  assign rxByte   = {rxShift, mosiS};
  assign byteDone = rise && (bitCnt == 3'd7);
  assign nextPtr  = isMulti ? ptr + 1'b1 : ptr;

  always_comb begin
    strb           = '0;
    strb.frameIdle = csS;
    strb.fallEdge  = fall;
    strb.txActive  = !inCmd;
    strb.bitIdx    = bitCnt;
    strb.wrData    = rxByte;
    if (byteDone) begin
      strb.loadTx = 1'b1;
      if (inCmd) begin
        strb.loadAddr = rxByte[ADDR_W-1:0];
      end else begin
        strb.loadAddr  = nextPtr;
        strb.writeCtrl = !isRead && (ptr == CTRL_ADDR);
      end
    end
    // pop on the last data byte, or on release after a data byte
    strb.popNow = !popped &&
                  ((byteDone && !inCmd && isRead && (ptr == LAST_DATA)) ||
                   (csRise && touched));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCmd   <= 1'b1;
      bitCnt  <= '0;
      rxShift <= '0;
      isRead  <= 1'b0;
      isMulti <= 1'b0;
      ptr     <= '0;
      touched <= 1'b0;
      popped  <= 1'b0;
    end else if (csS) begin
      inCmd   <= 1'b1;
      bitCnt  <= '0;
      touched <= 1'b0;
      popped  <= 1'b0;
    end else if (rise) begin
      rxShift <= rxByte[6:0];
      bitCnt  <= bitCnt + 3'd1;
      if (byteDone) begin
        if (inCmd) begin
          inCmd   <= 1'b0;
          isRead  <= rxByte[7];
          isMulti <= rxByte[6];
          ptr     <= rxByte[ADDR_W-1:0];
        end else begin
          ptr <= nextPtr;
          if (isRead && ptr >= DATA_BASE && ptr <= LAST_DATA) touched <= 1'b1;
          if (strb.popNow) popped <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/burst_reg_dp.sv
module burst_reg_dp
  import burst_reg_pkg::*;
#(
  parameter int                NUM_DATA   = 6,
  parameter int                COUNT_W    = 6,
  parameter int                POP_SETTLE = 200,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 6'h32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'h38,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 6'h39
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  portStrobes_t          strb,
  input  logic [NUM_DATA*8-1:0] fifoHead,
  input  logic [COUNT_W-1:0]    fifoCount,
  input  logic                  fifoTriggered,
  output logic                  spiMiso,
  output logic [7:0]            ctrlReg
);
  localparam int SETTLE_W = $clog2(POP_SETTLE + 1);

  logic [7:0] txByte, rdByte, statusSnap;
  logic [SETTLE_W-1:0] settleCnt;
  logic settleBusy;

  assign settleBusy = (settleCnt != '0);

  always_comb begin
    rdByte = '0;
    if (strb.loadAddr == CTRL_ADDR) rdByte = ctrlReg;
    if (strb.loadAddr == STAT_ADDR) rdByte = statusSnap;
    for (int i = 0; i < NUM_DATA; i++) begin
      if (strb.loadAddr == DATA_BASE + ADDR_W'(i)) rdByte = fifoHead[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte     <= '0;
      spiMiso    <= 1'b0;
      ctrlReg    <= '0;
      settleCnt  <= '0;
      statusSnap <= '0;
    end else begin
      if (strb.loadTx) txByte <= rdByte;
      if (strb.frameIdle)     spiMiso <= 1'b0;
      else if (strb.fallEdge) spiMiso <= strb.txActive & txByte[3'd7 - strb.bitIdx];
      if (strb.writeCtrl) ctrlReg <= strb.wrData;
      if (strb.popNow)    settleCnt <= SETTLE_W'(POP_SETTLE);
      else if (settleBusy) settleCnt <= settleCnt - 1'b1;
      if (!strb.popNow && !settleBusy)
        statusSnap <= {fifoTriggered, 1'b0, fifoCount};
    end
  end
endmodule

// File: rtl/burst_reg_port.sv
module burst_reg_port
  import burst_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_DATA    = 6,
  parameter int COUNT_W     = 6,
  parameter int POP_SETTLE  = 200
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spiCsN,
  input  logic                  spiSclk,
  input  logic                  spiMosi,
  output logic                  spiMiso,
  input  logic [NUM_DATA*8-1:0] fifoHead,
  input  logic [COUNT_W-1:0]    fifoCount,
  input  logic                  fifoTriggered,
  output logic                  fifoPop,
  output logic [1:0]            ctrlMode,
  output logic                  ctrlTrigSel,
  output logic [4:0]            ctrlSamples
);
  localparam logic [ADDR_W-1:0] DATA_BASE = 6'h32;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = DATA_BASE + ADDR_W'(NUM_DATA);
  localparam logic [ADDR_W-1:0] STAT_ADDR = CTRL_ADDR + 1'b1;

  portStrobes_t strb;
  logic [7:0] ctrlReg;

  burst_reg_ctl #(
    .SYNC_STAGES(SYNC_STAGES), .NUM_DATA(NUM_DATA),
    .DATA_BASE(DATA_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .strb(strb)
  );

  burst_reg_dp #(
    .NUM_DATA(NUM_DATA), .COUNT_W(COUNT_W), .POP_SETTLE(POP_SETTLE),
    .DATA_BASE(DATA_BASE), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoHead(fifoHead),
    .fifoCount(fifoCount), .fifoTriggered(fifoTriggered),
    .spiMiso(spiMiso), .ctrlReg(ctrlReg)
  );

  assign fifoPop     = strb.popNow;
  assign ctrlMode    = ctrlReg[7:6];
  assign ctrlTrigSel = ctrlReg[5];
  assign ctrlSamples = ctrlReg[4:0];
endmodule

// File: rtl/burst_reg_port_chk.sv
module burst_reg_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       spiMiso,
  input logic       fifoPop,
  input logic       ctrlWrite,
  input logic [7:0] ctrlBits,
  input logic       settleBusy,
  input logic [7:0] statusSnap
);
  logic [2:0] csHighCnt;
  logic [1:0] popsInFrame;
  logic csPrevRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighCnt   <= '0;
      popsInFrame <= '0;
      csPrevRaw   <= 1'b1;
    end else begin
      csPrevRaw <= spiCsN;
      if (!spiCsN) csHighCnt <= '0;
      else if (csHighCnt != 3'd7) csHighCnt <= csHighCnt + 3'd1;
      if (csPrevRaw && !spiCsN) popsInFrame <= '0;
      else if (fifoPop && popsInFrame != 2'd3) popsInFrame <= popsInFrame + 2'd1;
    end
  end

  // R7: only one pop per chip-select frame
  p_one_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (popsInFrame == 2'd0));

  // R7: pop request is a single-cycle pulse
  p_pop_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  // R10: status snapshot frozen while settling
  p_status_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    settleBusy |=> $stable(statusSnap));

  // R2: data out low once chip select has been high a while
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csHighCnt >= 3'd4) |-> !spiMiso);

  // R8: control outputs move only after a control write
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(ctrlBits));
endmodule

bind burst_reg_port burst_reg_port_chk u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiMiso(spiMiso),
  .fifoPop(fifoPop), .ctrlWrite(strb.writeCtrl),
  .ctrlBits({ctrlMode, ctrlTrigSel, ctrlSamples}),
  .settleBusy(u_dp.settleBusy), .statusSnap(u_dp.statusSnap)
);

// File: tb/burst_reg_port_tb.sv
module burst_reg_port_tb;
  localparam int HALF = 6;
  localparam int NVEC = 10;
  // {command, write data, expected read, expected pop}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'hB2, 8'h00, 8'hA0, 1'b1},
    {8'hB3, 8'h00, 8'hA9, 1'b1},
    {8'hB8, 8'h00, 8'h00, 1'b0},
    {8'hBF, 8'h00, 8'h00, 1'b0},
    {8'h38, 8'hC7, 8'h00, 1'b0},
    {8'hB8, 8'h00, 8'hC7, 1'b0},
    {8'h32, 8'hFF, 8'h00, 1'b0},
    {8'hB7, 8'h00, 8'hB5, 1'b1},
    {8'h3F, 8'h55, 8'h00, 1'b0},
    {8'hB8, 8'h00, 8'hC7, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b1, spiMosi = 1'b0;
  logic spiMiso, fifoPop, ctrlTrigSel;
  logic [47:0] fifoHead;
  logic [5:0] fifoCount;
  logic [1:0] ctrlMode;
  logic [4:0] ctrlSamples;
  int head, pops, checks, errors;
  logic [7:0] rxBuf [8];
  logic [7:0] rb;

  always #4 clk = ~clk;

  burst_reg_port u_dut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .fifoHead(fifoHead),
    .fifoCount(fifoCount), .fifoTriggered(1'b1), .fifoPop(fifoPop),
    .ctrlMode(ctrlMode), .ctrlTrigSel(ctrlTrigSel), .ctrlSamples(ctrlSamples)
  );

  // queue model: sample k byte j = A0 + 8k + j
  always_comb
    for (int j = 0; j < 6; j++) fifoHead[8*j +: 8] = 8'(8'hA0 + 8*head + j);

  always @(negedge clk) begin
    if (!rstN) begin
      head = 0; fifoCount = 6'd20; pops = 0;
    end else if (fifoPop) begin
      head = head + 1; fifoCount = fifoCount - 6'd1; pops = pops + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); spiSclk = 1'b0; spiMosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spiMiso;
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic csLow();
    @(negedge clk); spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk); spiCsN = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic doFrame(input logic [7:0] cmd, input int n, input logic [7:0] wd);
    logic [7:0] r;
    csLow();
    xferByte(cmd, r);
    for (int b = 0; b < n; b++) begin
      xferByte(wd, r);
      rxBuf[b] = r;
    end
    csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R8 reset ctrl", {ctrlMode, ctrlTrigSel, ctrlSamples}, 8'h00);
    chk("R2 idle miso", spiMiso, 1'b0);
    chk("R7 no pop at reset", fifoPop, 1'b0);

    // table of single-byte frames
    for (int v = 0; v < NVEC; v++) begin
      p0 = pops;
      doFrame(VEC[v][24:17], 1, VEC[v][16:9]);
      if (VEC[v][24]) chk($sformatf("R3 R11 R8 vec %0d read", v), rxBuf[0], VEC[v][8:1]);
      chk($sformatf("R6 vec %0d pop", v), pops - p0, 32'(VEC[v][0]));
      chk("R2 miso low between frames", spiMiso, 1'b0);
    end

    // burst through data, control and status; pop before release
    p0 = pops;
    csLow();
    xferByte(8'hF2, rb);
    for (int b = 0; b < 6; b++) begin
      xferByte(8'h00, rb);
      chk($sformatf("R3 R4 burst byte %0d", b), rb, 8'(8'hB8 + b));
    end
    chk("R5 pop before release", pops - p0, 1);
    xferByte(8'h00, rb);
    chk("R4 burst ctrl byte", rb, 8'hC7);
    xferByte(8'h00, rb);
    chk("R10 stale status", rb, 8'h91);
    csHigh();
    chk("R7 one pop in burst", pops - p0, 1);

    // status after settling
    repeat (300) @(negedge clk);
    p0 = pops;
    doFrame(8'hB9, 1, 8'h00);
    chk("R9 R10 fresh status", rxBuf[0], 8'h90);
    chk("R6 status read no pop", pops - p0, 0);

    // no auto-increment: same byte repeated, one pop at release
    p0 = pops;
    doFrame(8'hB4, 3, 8'h00);
    chk("R4 repeat byte 0", rxBuf[0], 8'hC2);
    chk("R4 repeat byte 2", rxBuf[2], 8'hC2);
    chk("R6 R7 one pop on release", pops - p0, 1);

    // command-only frame
    p0 = pops;
    doFrame(8'hB2, 0, 8'h00);
    chk("R6 command only no pop", pops - p0, 0);

    // burst from Z low past the data block
    p0 = pops;
    doFrame(8'hF6, 3, 8'h00);
    chk("R3 Z low", rxBuf[0], 8'hCC);
    chk("R3 Z high", rxBuf[1], 8'hCD);
    chk("R4 run into ctrl", rxBuf[2], 8'hC7);
    chk("R5 R7 one pop", pops - p0, 1);

    // auto-increment write: ctrl then status (ignored)
    doFrame(8'h78, 2, 8'h5A);
    chk("R1 R8 ctrl mode", ctrlMode, 2'b01);
    chk("R8 ctrl trigger select", ctrlTrigSel, 1'b0);
    chk("R8 ctrl samples", ctrlSamples, 5'h1A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule